// File: doc/BRIEF.md
# Pipelined Burst Static Memory

This block is a synchronous static memory that stores words made of byte lanes. Each lane holds nine bits: eight data bits and one parity bit. Every control input is sampled on the rising clock edge. A new address can be loaded by one of two load strobes. After a load, a two-bit burst counter produces the next three addresses of the aligned group of four. The order of those addresses is linear or interleaved. A step input chooses, cycle by cycle, whether the burst moves to the next address or holds the current one.

Reads go through two registers. An access registered on edge n drives its word on the outputs after edge n+1, which gives a first-access pattern of 3-1-1-1. Writes take their data on the same edge as the write controls and commit it on that edge. A write can cover all lanes through a global write input, or selected lanes through a gated per-lane enable. A read that follows a write returns the freshly written lanes through a pass-through path. The output enable is combinational: when it is high, the data outputs are forced to the released (high-impedance) state.

The high-impedance state is modelled as `rdata_vld` low with `rdata` at zero. The array depth is 2^ADDR_W words.

Top module: `pburst_sram`

## Requirements
- R1: Lane i of a word is bits [9i+8:9i], with the parity bit at the top of each lane (bits 8 and 17 for two lanes). When `wr_lane_gate_n` is low, each lane whose `lane_wr_n[i]` is low is written, and every other lane keeps its stored contents.
- R2: When `wr_all_n` is low on a write-capable access, every lane is written, whatever `wr_lane_gate_n` and `lane_wr_n` hold.
- R3: When `wr_all_n` and `wr_lane_gate_n` are both high, the access is a read and `lane_wr_n` has no effect. When `wr_lane_gate_n` is low but no lane enable is low, the access is also a read.
- R4: `lda_n` low counts only when `sel_a_n` is low. When `lda_n` is low and `sel_a_n` is high, the strobe is ignored and the cycle behaves as a step cycle. A counted `lda_n` load with all enables active is always a read, even if the write controls are asserted.
- R5: Write controls asserted on the hold cycle (`step_n` high) that follows an `lda_n` load write the address that was loaded.
- R6: A counted load strobe while any enable is inactive deselects the block: the active burst ends, later step cycles make no access, and the outputs are released. Enables are active when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low.
- R7: `ldb_n` low with all enables active loads `addr` and accesses it at once, as a read or a write according to the write controls.
- R8: A cycle with no counted strobe and `step_n` low moves an active burst to the next address. The two low address bits are base+count modulo 4 when `lin_order` is 1, and base XOR count when it is 0. The upper address bits stay fixed.
- R9: A cycle with no counted strobe and `step_n` high accesses the current burst address again.
- R10: A read access registered on edge n drives its word with `rdata_vld` high from edge n+1 until edge n+2. Consecutive read accesses give one word per cycle.
- R11: While `out_en_n` is high, `rdata_vld` is low and `rdata` is zero. The effect is immediate and does not wait for a clock edge.
- R12: A read of a word that was just written returns the written lanes merged with the lanes that were not written.
- R13: After reset, the outputs are released and no burst is active, so step cycles make no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| sel_a_n | input | 1 | Primary enable, active low; also qualifies `lda_n` |
| sel_b | input | 1 | Enable, active high |
| sel_c_n | input | 1 | Enable, active low |
| lda_n | input | 1 | Read-only load strobe, active low |
| ldb_n | input | 1 | General load strobe, active low |
| step_n | input | 1 | Low: advance the burst; high: hold the address |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_lane_gate_n | input | 1 | Gate for the per-lane enables, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| lin_order | input | 1 | 1: linear burst order; 0: interleaved order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 9*LANES | Write data |
| rdata | output | 9*LANES | Read data; zero when released |
| rdata_vld | output | 1 | High when `rdata` is driven |

## Verification
The bench builds the block with ADDR_W = 6, which gives 64 words, and keeps the default two 9-bit lanes. With only 64 words, the reference memory stays small, and an aligned group at the top of the address space is easy to reach. The bench loads the last word there to show that a linear burst wraps to the start of its group of four and keeps the upper bits. Two lanes are enough to cover both single-lane write patterns and their merge in pass-through.

// File: rtl/pburst_pkg.sv
package pburst_pkg;

  typedef enum logic [1:0] {
    CY_STEP  = 2'd0,
    CY_LOAD  = 2'd1,
    CY_DESEL = 2'd2
  } cyc_e;

  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       lin);
    return lin ? (base + cnt) : (base ^ cnt);
  endfunction

endpackage

// File: rtl/pburst_decode.sv
module pburst_decode
  import pburst_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             lda_n,
  input  logic             ldb_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  output cyc_e             cyc,
  output logic             proc_load,
  output logic [LANES-1:0] lane_mask
);

  logic sel_ok;
  logic lda_hit;
  logic strobe;

  assign sel_ok    = ~sel_a_n & sel_b & ~sel_c_n;
  assign lda_hit   = ~lda_n & ~sel_a_n;
  assign strobe    = lda_hit | ~ldb_n;
  assign proc_load = lda_hit & sel_ok;

  always_comb begin
    if (!strobe)      cyc = CY_STEP;
    else if (sel_ok)  cyc = CY_LOAD;
    else              cyc = CY_DESEL;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign lane_mask[i] = ~wr_all_n | (~wr_lane_gate_n & ~lane_wr_n[i]);
  end

endmodule

// File: rtl/pburst_seq.sv
module pburst_seq
  import pburst_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              cyc,
  input  logic              step_n,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc,
  output logic [ADDR_W-1:0] acc_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              active_q;
  logic              step_ok;
  logic [1:0]        cnt_nx;

  assign step_ok = (cyc == CY_STEP) && active_q;
  assign cnt_nx  = (step_ok && !step_n) ? cnt_q + 2'd1 : cnt_q;
  assign acc     = (cyc == CY_LOAD) || step_ok;

  always_comb begin
    if (cyc == CY_LOAD)
      acc_addr = addr;
    else
      acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, lin_order)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= 2'd0;
      base_q   <= '0;
    end else begin
      case (cyc)
        CY_LOAD: begin
          active_q <= 1'b1;
          base_q   <= addr;
          cnt_q    <= 2'd0;
        end
        CY_DESEL: active_q <= 1'b0;
        default:  cnt_q <= cnt_nx;
      endcase
    end
  end

  // R9: a hold cycle leaves the burst position untouched
  p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc == CY_STEP && active_q && step_n) |=> ($stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/pburst_mem.sv
module pburst_mem #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANE_W*LANES-1:0]   wdata,
  output logic [LANE_W*LANES-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we[i]) cells[addr] <= wdata[i*LANE_W +: LANE_W];
      q <= cells[addr];
    end

    assign rdata[i*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/pburst_out.sv
module pburst_out #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_cyc,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic [LANE_W*LANES-1:0] wdata,
  input  logic [LANE_W*LANES-1:0] ram_q,
  input  logic                    out_en_n,
  output logic [LANE_W*LANES-1:0] rdata,
  output logic                    rdata_vld
);

  localparam int W = LANE_W * LANES;

  logic              lw_valid;
  logic [ADDR_W-1:0] lw_addr;
  logic [LANES-1:0]  lw_mask;
  logic [W-1:0]      lw_data;
  logic              rd_v1;
  logic              hit1;
  logic [LANES-1:0]  hit_mask1;
  logic [W-1:0]      byp1;
  logic              vld2;
  logic [W-1:0]      q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_valid <= 1'b0;
      rd_v1    <= 1'b0;
      hit1     <= 1'b0;
      vld2     <= 1'b0;
    end else begin
      if (|we) lw_valid <= 1'b1;
      rd_v1 <= rd_cyc;
      hit1  <= rd_cyc && lw_valid && (lw_addr == addr);
      vld2  <= rd_v1;
    end
  end

  always_ff @(posedge clk) begin
    if (|we) begin
      lw_addr <= addr;
      lw_mask <= we;
      lw_data <= wdata;
    end
    hit_mask1 <= lw_mask;
    byp1      <= lw_data;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_q
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      lane_q <= (hit1 && hit_mask1[i]) ? byp1[i*LANE_W +: LANE_W]
                                       : ram_q[i*LANE_W +: LANE_W];
    end
    assign q2[i*LANE_W +: LANE_W] = lane_q;
  end

  assign rdata_vld = vld2 & ~out_en_n;
  assign rdata     = rdata_vld ? q2 : '0;

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
  import pburst_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    lda_n,
  input  logic                    ldb_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_gate_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    lin_order,
  input  logic                    out_en_n,
  input  logic [LANE_W*LANES-1:0] wdata,
  output logic [LANE_W*LANES-1:0] rdata,
  output logic                    rdata_vld
);

  localparam int WORD_W = LANE_W * LANES;

  cyc_e              cyc;
  logic              proc_load;
  logic [LANES-1:0]  lane_mask;
  logic [LANES-1:0]  arr_we;
  logic              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic              wr_en;
  logic              rd_cyc;
  logic [WORD_W-1:0] ram_q;

  pburst_decode #(.LANES(LANES)) u_dec (
    .sel_a_n        (sel_a_n),
    .sel_b          (sel_b),
    .sel_c_n        (sel_c_n),
    .lda_n          (lda_n),
    .ldb_n          (ldb_n),
    .wr_all_n       (wr_all_n),
    .wr_lane_gate_n (wr_lane_gate_n),
    .lane_wr_n      (lane_wr_n),
    .cyc            (cyc),
    .proc_load      (proc_load),
    .lane_mask      (lane_mask)
  );

  pburst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cyc       (cyc),
    .step_n    (step_n),
    .lin_order (lin_order),
    .addr      (addr),
    .acc       (acc),
    .acc_addr  (acc_addr)
  );

  assign wr_en  = acc & ~proc_load & (|lane_mask);
  assign arr_we = wr_en ? lane_mask : '0;
  assign rd_cyc = acc & ~wr_en;

  pburst_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk   (clk),
    .we    (arr_we),
    .addr  (acc_addr),
    .wdata (wdata),
    .rdata (ram_q)
  );

  pburst_out #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_cyc    (rd_cyc),
    .addr      (acc_addr),
    .we        (arr_we),
    .wdata     (wdata),
    .ram_q     (ram_q),
    .out_en_n  (out_en_n),
    .rdata     (rdata),
    .rdata_vld (rdata_vld)
  );

  // R6: a deselect leaves the outputs released two edges later
  p_desel_hiz_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc == CY_DESEL) |=> ##1 !rdata_vld);

  // R10: a read access drives its word after the following edge
  p_read_lat_r10: assert property (@(posedge clk) disable iff (rst)
    rd_cyc |=> ##1 (rdata_vld || out_en_n));

  // R4: a counted read-only load produces read data
  p_proc_read_r4: assert property (@(posedge clk) disable iff (rst)
    proc_load |=> ##1 (rdata_vld || out_en_n));

  // R2: a global write reaches every lane of the array
  p_gw_lanes_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_all_n) |-> (arr_we == '1));

endmodule

// File: tb/sim_pburst_sram.sv
module sim_pburst_sram;

  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int WW = LW * NL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          lda_n = 1'b1, ldb_n = 1'b1, step_n = 1'b1;
  logic          wr_all_n = 1'b1, wr_lane_gate_n = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic          lin_order = 1'b1;
  logic          out_en_n = 1'b0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic          rdata_vld;

  always #4 clk = ~clk;

  pburst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .lda_n(lda_n), .ldb_n(ldb_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lane_gate_n(wr_lane_gate_n), .lane_wr_n(lane_wr_n),
    .lin_order(lin_order), .out_en_n(out_en_n), .wdata(wdata),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  int checks = 0;
  int errors = 0;
  int edge_no = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  string idle_tag = "R13";

  int            q_due [$];
  logic [WW-1:0] q_dat [$];
  string         q_tag [$];

  logic [WW-1:0] mm [64];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            m_act = 1'b0;

  always @(posedge clk) edge_no++;

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%h vld=%0b expected=%h", tag, edge_no,
               act, rdata_vld, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [WW-1:0] pat(input int a, input int k);
    return WW'((a * 18'h2B7) ^ (k * 18'h1357) ^ 18'h2A5A5);
  endfunction

  // One bus cycle; called just after a falling edge, returns after the next one.
  task automatic cyc(input bit ap_n, input bit ac_n, input bit s1_n, input bit s2,
                     input bit s3_n, input bit av_n, input bit g_n, input bit b_n,
                     input logic [NL-1:0] l_n, input logic [AW-1:0] a,
                     input logic [WW-1:0] d, input string tag);
    bit sel, phit, strobe, acc, pload, wr;
    logic [NL-1:0] mask;
    logic [AW-1:0] ea;
    lda_n = ap_n; ldb_n = ac_n; sel_a_n = s1_n; sel_b = s2; sel_c_n = s3_n;
    step_n = av_n; wr_all_n = g_n; wr_lane_gate_n = b_n; lane_wr_n = l_n;
    addr = a; wdata = d;
    sel    = !s1_n && s2 && !s3_n;
    phit   = !ap_n && !s1_n;
    strobe = phit || !ac_n;
    mask   = {NL{!g_n}} | ({NL{!b_n}} & ~l_n);
    acc = 1'b0; pload = 1'b0; ea = '0;
    if (strobe) begin
      if (sel) begin
        acc = 1'b1; pload = phit; ea = a;
        m_base = a; m_cnt = 2'd0; m_act = 1'b1;
      end else m_act = 1'b0;
    end else if (m_act) begin
      acc = 1'b1;
      if (!av_n) m_cnt = m_cnt + 2'd1;
      ea = {m_base[AW-1:2], lin_order ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt};
    end
    wr = acc && !pload && (mask != '0);
    if (wr) begin
      for (int i = 0; i < NL; i++)
        if (mask[i]) mm[ea][i*LW +: LW] = d[i*LW +: LW];
    end else if (acc) begin
      q_due.push_back(edge_no + 2);
      q_dat.push_back(mm[ea]);
      q_tag.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic desel(input string tag);
    cyc(1, 0, 1, 1, 0, 1, 1, 1, 2'b11, '0, '0, tag);
  endtask
  task automatic ldw(input logic [AW-1:0] a, input logic [WW-1:0] d, input string tag);
    cyc(1, 0, 0, 1, 0, 1, 0, 1, 2'b11, a, d, tag);
  endtask
  task automatic ldr(input logic [AW-1:0] a, input string tag);
    cyc(1, 0, 0, 1, 0, 1, 1, 1, 2'b11, a, '0, tag);
  endtask
  task automatic stw(input logic [WW-1:0] d, input string tag);
    cyc(1, 1, 0, 1, 0, 0, 0, 1, 2'b11, '0, d, tag);
  endtask
  task automatic str(input bit av_n, input string tag);
    cyc(1, 1, 0, 1, 0, av_n, 1, 1, 2'b11, '0, '0, tag);
  endtask

  // Monitor: pops expected words when due, otherwise expects released outputs.
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      while (q_due.size() > 0 && q_due[0] < edge_no) begin
        chk(1'b0, {q_tag[0], " missed"}, rdata, q_dat[0]);
        void'(q_due.pop_front()); void'(q_dat.pop_front()); void'(q_tag.pop_front());
      end
      if (q_due.size() > 0 && q_due[0] == edge_no) begin
        if (out_en_n)
          chk(!rdata_vld && rdata == '0, {q_tag[0], " R11 released"}, rdata, '0);
        else
          chk(rdata_vld && rdata == q_dat[0], q_tag[0], rdata, q_dat[0]);
        void'(q_due.pop_front()); void'(q_dat.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk(!rdata_vld, {idle_tag, " idle"}, rdata, '0);
      end
    end
  end

  always @(posedge clk) begin
    if (edge_no > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog R10: actual=timeout expected=finish");
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk(!rdata_vld && rdata == '0, "R13 reset released", rdata, '0);
    @(negedge clk);
    mon_on = 1'b1;

    // R13: step cycles after reset make no access
    idle_tag = "R13";
    str(0, "R13");
    str(1, "R13");
    // the reference memory starts at zero, so clear 0..63 first through bursts
    for (int g = 0; g < 16; g++) begin
      ldw(6'(g*4), '0, "R7");
      for (int s = 0; s < 3; s++) stw('0, "R8");
    end
    desel("R6");

    // R7 R2 R8: fill 8..11 with a linear write burst
    idle_tag = "R10";
    lin_order = 1'b1;
    ldw(8, pat(8, 1), "R7");
    stw(pat(9, 1), "R8");
    stw(pat(10, 1), "R8");
    stw(pat(11, 1), "R8");
    desel("R6");

    // R8 interleaved read from 10: 10,11,8,9
    lin_order = 1'b0;
    ldr(10, "R7 read");
    str(0, "R8 interleaved");
    str(0, "R8 interleaved");
    str(0, "R8 interleaved");
    desel("R6"); desel("R6");

    // R8 linear read from 9: 9,10,11,8
    lin_order = 1'b1;
    ldr(9, "R10 first");
    str(0, "R8 linear");
    str(0, "R8 linear");
    str(0, "R8 linear");
    desel("R6"); desel("R6");

    // R8 top group wrap: 63,60,61,62
    ldw(60, pat(60, 2), "R7");
    stw(pat(61, 2), "R8");
    stw(pat(62, 2), "R8");
    stw(pat(63, 2), "R8");
    ldr(63, "R8 wrap");
    str(0, "R8 wrap");
    str(0, "R8 wrap");
    str(0, "R8 wrap");
    desel("R6"); desel("R6");

    // R9: hold and advance mixed
    ldr(8, "R9");
    str(1, "R9 hold");
    str(0, "R9 advance");
    str(1, "R9 hold");
    desel("R6"); desel("R6");

    // R1 R12: lane writes followed at once by reads
    ldw(20, pat(20, 3), "R2");
    desel("R6");
    cyc(1, 0, 0, 1, 0, 1, 1, 0, 2'b10, 20, pat(20, 4), "R1");
    str(1, "R12 lane0 merge");
    cyc(1, 0, 0, 1, 0, 1, 1, 0, 2'b01, 20, pat(20, 5), "R1");
    ldr(20, "R12 lane1 merge");
    desel("R6"); desel("R6");

    // R3: lane enables ignored without the gate; empty lane set is a read
    cyc(1, 0, 0, 1, 0, 1, 1, 1, 2'b00, 20, pat(20, 6), "R3 no gate");
    cyc(1, 0, 0, 1, 0, 1, 1, 0, 2'b11, 20, pat(20, 7), "R3 no lanes");
    ldr(20, "R3 unchanged");
    desel("R6"); desel("R6");

    // R4 R5: read-only load ignores write controls; write on the hold cycle
    ldw(24, pat(24, 1), "R7");
    cyc(0, 1, 0, 1, 0, 1, 0, 0, 2'b00, 24, pat(24, 8), "R4 read only");
    cyc(1, 1, 0, 1, 0, 1, 0, 1, 2'b11, '0, pat(24, 9), "R5");
    desel("R6");
    ldr(24, "R5 written");
    desel("R6"); desel("R6");

    // R4: lda_n ignored while sel_a_n is high; acts as a hold step
    ldr(8, "R7 read");
    cyc(0, 1, 1, 1, 0, 1, 1, 1, 2'b11, 40, '0, "R4 ignored");
    desel("R6"); desel("R6");

    // R6: deselect through each enable, then steps make no access
    idle_tag = "R6";
    ldr(8, "R7 read");
    cyc(1, 0, 0, 0, 0, 1, 1, 1, 2'b11, 9, '0, "R6");
    str(0, "R6");
    str(1, "R6");
    ldr(9, "R7 read");
    cyc(0, 1, 0, 1, 1, 1, 1, 1, 2'b11, 10, '0, "R6");
    str(0, "R6");
    str(0, "R6");

    // R11: output enable high releases the outputs during a burst
    idle_tag = "R11";
    out_en_n = 1'b1;
    ldr(8, "R11");
    str(0, "R11");
    str(0, "R11");
    str(0, "R11");
    desel("R6"); desel("R6"); desel("R6");
    out_en_n = 1'b0;
    ldr(11, "R11 restored");
    desel("R6"); desel("R6"); desel("R6");

    checks++;
    if (q_due.size() != 0) begin
      errors++;
      $display("FAIL R10 pending words: actual=%0d expected=0", q_due.size());
    end
    finish_up();
  end

endmodule